// File: doc/BRIEF.md
# Lane Region Request Splitter

This block sits between a multi-lane load/store unit and two memory targets: a local scratchpad and a data cache. Each incoming vector request has a lane-enable mask, one address slot per lane, a write flag, a tag, a core identifier and a transaction identifier. Every enabled lane is classified by its address. An address inside a parameterised shared window goes to the scratchpad. Any other address goes to the cache. One input request therefore yields up to two partial-mask sub-requests.

Each outgoing path runs through a fixed-length delay line of `DELAY` stages. The input is taken only when every path it needs can shift. On the return side, responses from both targets are merged onto one upstream port. The scratchpad side wins when both are present.

Top module: `lane_region_splitter`

## Requirements
- R1: An enabled lane whose address `a` satisfies `SHARED_BASE <= a < SHARED_BASE + SHARED_SIZE` has its bit set in the scratchpad sub-request (`lmReq*`). Any other enabled lane has its bit set in the cache sub-request (`dcReq*`). Bit i of a mask is lane i, and lane i's address is bits `[i*ADDR_W +: ADDR_W]` of the address bus.
- R2: In each sub-request, a lane not routed to that path has its mask bit at 0 and its address slot at zero.
- R3: Each sub-request carries the write flag, tag, core and transaction identifiers of its input request, unchanged.
- R4: A sub-request is raised only when its mask is non-zero. An input whose enabled lanes all fall in one region produces exactly one sub-request. An input with an all-zero mask is accepted and produces none.
- R5: On an idle path, a request accepted at the end of cycle c shows its sub-request valid in cycle c+DELAY, and not earlier.
- R6: `inReady` is high exactly when every path that the presented request needs can shift its delay line. A stall on a path the request does not need does not block it.
- R7: A sub-request held with its ready low keeps valid and contents stable. Sub-requests on one path leave in acceptance order.
- R8: Response merge: `upRspValid` is the OR of both response valids. The scratchpad response's mask, tag, core and transaction are forwarded unchanged when it is valid, and otherwise the cache response's are. `lmRspReady` equals `upRspReady`. `dcRspReady` is `upRspReady` and not `lmRspValid`.
- R9: After reset, no sub-request valid and no upstream response valid is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Vector request present |
| inReady | output | 1 | Vector request taken this cycle |
| inMask | input | LANES | Lane enables |
| inAddr | input | LANES*ADDR_W | Per-lane addresses |
| inWrite | input | 1 | Store when high |
| inTag | input | TAG_W | Request tag |
| inCore | input | CORE_W | Core identifier |
| inTxn | input | TXN_W | Transaction identifier |
| lmReqValid | output | 1 | Scratchpad sub-request valid |
| lmReqReady | input | 1 | Scratchpad accepts |
| lmReqMask | output | LANES | Scratchpad lane mask |
| lmReqAddr | output | LANES*ADDR_W | Scratchpad address slots |
| lmReqWrite | output | 1 | Write flag |
| lmReqTag | output | TAG_W | Tag |
| lmReqCore | output | CORE_W | Core identifier |
| lmReqTxn | output | TXN_W | Transaction identifier |
| dcReqValid | output | 1 | Cache sub-request valid |
| dcReqReady | input | 1 | Cache accepts |
| dcReqMask | output | LANES | Cache lane mask |
| dcReqAddr | output | LANES*ADDR_W | Cache address slots |
| dcReqWrite | output | 1 | Write flag |
| dcReqTag | output | TAG_W | Tag |
| dcReqCore | output | CORE_W | Core identifier |
| dcReqTxn | output | TXN_W | Transaction identifier |
| lmRspValid | input | 1 | Scratchpad response valid |
| lmRspReady | output | 1 | Scratchpad response taken |
| lmRspMask | input | LANES | Scratchpad response lanes |
| lmRspTag | input | TAG_W | Scratchpad response tag |
| lmRspCore | input | CORE_W | Scratchpad response core |
| lmRspTxn | input | TXN_W | Scratchpad response transaction |
| dcRspValid | input | 1 | Cache response valid |
| dcRspReady | output | 1 | Cache response taken |
| dcRspMask | input | LANES | Cache response lanes |
| dcRspTag | input | TAG_W | Cache response tag |
| dcRspCore | input | CORE_W | Cache response core |
| dcRspTxn | input | TXN_W | Cache response transaction |
| upRspValid | output | 1 | Merged response valid |
| upRspReady | input | 1 | Load/store unit accepts response |
| upRspMask | output | LANES | Merged response lanes |
| upRspTag | output | TAG_W | Merged response tag |
| upRspCore | output | CORE_W | Merged response core |
| upRspTxn | output | TXN_W | Merged response transaction |

## Verification
`inReady` and the response merge are combinational, so they are checked within the same cycle, one time unit after the inputs settle at the falling edge. Sub-requests are due DELAY rising edges after the accepting edge. For each swept vector, the bench checks for no valid one edge after acceptance, then checks the full sub-request contents at the falling edge after the second rising edge. The stall sequence checks that the head stays unchanged across a blocked edge, and then that the queued requests drain one per edge in acceptance order.

// File: rtl/lrs_pkg.sv
package lrs_pkg;
  localparam int PATH_LM = 0;
  localparam int PATH_DC = 1;

  // strobes from control to datapath
  typedef struct packed {
    logic [1:0] shift;     // advance delay line of each path
    logic [1:0] fill;      // head stage of each path takes a live sub-request
    logic       pickLocal; // response mux selects scratchpad side
  } strobeT;
endpackage

// File: rtl/lrs_ctrl.sv
module lrs_ctrl
  import lrs_pkg::*;
#(
  parameter int DELAY = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] need,
  input  logic [1:0] outReady,
  input  logic       lmRspValid,
  input  logic       dcRspValid,
  input  logic       upRspReady,
  output logic       inReady,
  output logic [1:0] outValid,
  output logic       lmRspReady,
  output logic       dcRspReady,
  output logic       upRspValid,
  output strobeT     stb
);
  localparam int LAST = DELAY - 1;

  logic [1:0][DELAY-1:0] validQ;
  logic accept;

  always_comb begin
    for (int p = 0; p < 2; p++) begin
      stb.shift[p] = !validQ[p][LAST] || outReady[p];
      outValid[p]  = validQ[p][LAST];
    end
    inReady = (!need[PATH_LM] || stb.shift[PATH_LM]) &&
              (!need[PATH_DC] || stb.shift[PATH_DC]);
    accept  = inValid && inReady;
    for (int p = 0; p < 2; p++) begin
      stb.fill[p] = accept && need[p];
    end
    stb.pickLocal = lmRspValid;
    upRspValid    = lmRspValid || dcRspValid;
    lmRspReady    = upRspReady;
    dcRspReady    = upRspReady && !lmRspValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (stb.shift[p]) begin
          for (int k = LAST; k >= 1; k--) begin
            validQ[p][k] <= validQ[p][k-1];
          end
          validQ[p][0] <= stb.fill[p];
        end
      end
    end
  end
endmodule

// File: rtl/lrs_datapath.sv
module lrs_datapath
  import lrs_pkg::*;
#(
  parameter int          LANES       = 4,
  parameter int          ADDR_W      = 8,
  parameter int          TAG_W       = 4,
  parameter int          CORE_W      = 2,
  parameter int          TXN_W       = 4,
  parameter int unsigned SHARED_BASE = 64,
  parameter int unsigned SHARED_SIZE = 32,
  parameter int          DELAY       = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic [LANES-1:0]                   inMask,
  input  logic [LANES*ADDR_W-1:0]            inAddr,
  input  logic                               inWrite,
  input  logic [TAG_W-1:0]                   inTag,
  input  logic [CORE_W-1:0]                  inCore,
  input  logic [TXN_W-1:0]                   inTxn,
  input  strobeT                             stb,
  output logic [1:0]                         need,
  output logic [1:0][LANES-1:0]              outMask,
  output logic [1:0][LANES*ADDR_W-1:0]       outAddr,
  output logic [1:0]                         outWrite,
  output logic [1:0][TAG_W-1:0]              outTag,
  output logic [1:0][CORE_W-1:0]             outCore,
  output logic [1:0][TXN_W-1:0]              outTxn,
  input  logic [LANES-1:0]                   lmRspMask,
  input  logic [TAG_W-1:0]                   lmRspTag,
  input  logic [CORE_W-1:0]                  lmRspCore,
  input  logic [TXN_W-1:0]                   lmRspTxn,
  input  logic [LANES-1:0]                   dcRspMask,
  input  logic [TAG_W-1:0]                   dcRspTag,
  input  logic [CORE_W-1:0]                  dcRspCore,
  input  logic [TXN_W-1:0]                   dcRspTxn,
  output logic [LANES-1:0]                   upRspMask,
  output logic [TAG_W-1:0]                   upRspTag,
  output logic [CORE_W-1:0]                  upRspCore,
  output logic [TXN_W-1:0]                   upRspTxn
);
  localparam int AW_ALL   = LANES * ADDR_W;
  localparam int OFF_TXN  = 0;
  localparam int OFF_CORE = OFF_TXN + TXN_W;
  localparam int OFF_TAG  = OFF_CORE + CORE_W;
  localparam int OFF_WR   = OFF_TAG + TAG_W;
  localparam int OFF_ADDR = OFF_WR + 1;
  localparam int OFF_MASK = OFF_ADDR + AW_ALL;
  localparam int PW       = OFF_MASK + LANES;
  localparam int LAST     = DELAY - 1;
  localparam logic [ADDR_W:0] WIN_LO = (ADDR_W+1)'(SHARED_BASE);
  localparam logic [ADDR_W:0] WIN_HI = (ADDR_W+1)'(SHARED_BASE + SHARED_SIZE);

  logic [LANES-1:0]       laneShared;
  logic [1:0][LANES-1:0]  splitMask;
  logic [1:0][AW_ALL-1:0] splitAddr;
  logic [1:0][PW-1:0]     headPay;
  logic [1:0][DELAY-1:0][PW-1:0] lineQ;

  // per-lane region decode and split
  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [ADDR_W-1:0] laneAddr;
    assign laneAddr      = inAddr[i*ADDR_W +: ADDR_W];
    assign laneShared[i] = ({1'b0, laneAddr} >= WIN_LO) && ({1'b0, laneAddr} < WIN_HI);
    assign splitMask[PATH_LM][i] = inMask[i] && laneShared[i];
    assign splitMask[PATH_DC][i] = inMask[i] && !laneShared[i];
    for (genvar p = 0; p < 2; p++) begin : gPath
      assign splitAddr[p][i*ADDR_W +: ADDR_W] = splitMask[p][i] ? laneAddr : '0;
    end
  end

  // per-path payload packing, delay line and unpacking
  for (genvar p = 0; p < 2; p++) begin : gOut
    logic [PW-1:0] tail;
    assign need[p]    = |splitMask[p];
    assign headPay[p] = {splitMask[p], splitAddr[p], inWrite, inTag, inCore, inTxn};

    always_ff @(posedge clk) begin
      if (!rstN) begin
        lineQ[p] <= '0;
      end else if (stb.shift[p]) begin
        for (int k = LAST; k >= 1; k--) begin
          lineQ[p][k] <= lineQ[p][k-1];
        end
        lineQ[p][0] <= stb.fill[p] ? headPay[p] : '0;
      end
    end

    assign tail        = lineQ[p][LAST];
    assign outMask[p]  = tail[OFF_MASK +: LANES];
    assign outAddr[p]  = tail[OFF_ADDR +: AW_ALL];
    assign outWrite[p] = tail[OFF_WR];
    assign outTag[p]   = tail[OFF_TAG +: TAG_W];
    assign outCore[p]  = tail[OFF_CORE +: CORE_W];
    assign outTxn[p]   = tail[OFF_TXN +: TXN_W];
  end

  // response merge, scratchpad first
  always_comb begin
    if (stb.pickLocal) begin
      upRspMask = lmRspMask;
      upRspTag  = lmRspTag;
      upRspCore = lmRspCore;
      upRspTxn  = lmRspTxn;
    end else begin
      upRspMask = dcRspMask;
      upRspTag  = dcRspTag;
      upRspCore = dcRspCore;
      upRspTxn  = dcRspTxn;
    end
  end
endmodule

// File: rtl/lane_region_splitter.sv
module lane_region_splitter
  import lrs_pkg::*;
#(
  parameter int          LANES       = 4,
  parameter int          ADDR_W      = 8,
  parameter int          TAG_W       = 4,
  parameter int          CORE_W      = 2,
  parameter int          TXN_W       = 4,
  parameter int unsigned SHARED_BASE = 64,
  parameter int unsigned SHARED_SIZE = 32,
  parameter int          DELAY       = 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  output logic                    inReady,
  input  logic [LANES-1:0]        inMask,
  input  logic [LANES*ADDR_W-1:0] inAddr,
  input  logic                    inWrite,
  input  logic [TAG_W-1:0]        inTag,
  input  logic [CORE_W-1:0]       inCore,
  input  logic [TXN_W-1:0]        inTxn,
  output logic                    lmReqValid,
  input  logic                    lmReqReady,
  output logic [LANES-1:0]        lmReqMask,
  output logic [LANES*ADDR_W-1:0] lmReqAddr,
  output logic                    lmReqWrite,
  output logic [TAG_W-1:0]        lmReqTag,
  output logic [CORE_W-1:0]       lmReqCore,
  output logic [TXN_W-1:0]        lmReqTxn,
  output logic                    dcReqValid,
  input  logic                    dcReqReady,
  output logic [LANES-1:0]        dcReqMask,
  output logic [LANES*ADDR_W-1:0] dcReqAddr,
  output logic                    dcReqWrite,
  output logic [TAG_W-1:0]        dcReqTag,
  output logic [CORE_W-1:0]       dcReqCore,
  output logic [TXN_W-1:0]        dcReqTxn,
  input  logic                    lmRspValid,
  output logic                    lmRspReady,
  input  logic [LANES-1:0]        lmRspMask,
  input  logic [TAG_W-1:0]        lmRspTag,
  input  logic [CORE_W-1:0]       lmRspCore,
  input  logic [TXN_W-1:0]        lmRspTxn,
  input  logic                    dcRspValid,
  output logic                    dcRspReady,
  input  logic [LANES-1:0]        dcRspMask,
  input  logic [TAG_W-1:0]        dcRspTag,
  input  logic [CORE_W-1:0]       dcRspCore,
  input  logic [TXN_W-1:0]        dcRspTxn,
  output logic                    upRspValid,
  input  logic                    upRspReady,
  output logic [LANES-1:0]        upRspMask,
  output logic [TAG_W-1:0]        upRspTag,
  output logic [CORE_W-1:0]       upRspCore,
  output logic [TXN_W-1:0]        upRspTxn
);
  strobeT                          stb;
  logic [1:0]                      need;
  logic [1:0]                      outValid;
  logic [1:0][LANES-1:0]           dpMask;
  logic [1:0][LANES*ADDR_W-1:0]    dpAddr;
  logic [1:0]                      dpWrite;
  logic [1:0][TAG_W-1:0]           dpTag;
  logic [1:0][CORE_W-1:0]          dpCore;
  logic [1:0][TXN_W-1:0]           dpTxn;

  lrs_ctrl #(.DELAY(DELAY)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .need       (need),
    .outReady   ({dcReqReady, lmReqReady}),
    .lmRspValid (lmRspValid),
    .dcRspValid (dcRspValid),
    .upRspReady (upRspReady),
    .inReady    (inReady),
    .outValid   (outValid),
    .lmRspReady (lmRspReady),
    .dcRspReady (dcRspReady),
    .upRspValid (upRspValid),
    .stb        (stb)
  );

  lrs_datapath #(
    .LANES(LANES), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CORE_W(CORE_W), .TXN_W(TXN_W),
    .SHARED_BASE(SHARED_BASE), .SHARED_SIZE(SHARED_SIZE), .DELAY(DELAY)
  ) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .inMask    (inMask),
    .inAddr    (inAddr),
    .inWrite   (inWrite),
    .inTag     (inTag),
    .inCore    (inCore),
    .inTxn     (inTxn),
    .stb       (stb),
    .need      (need),
    .outMask   (dpMask),
    .outAddr   (dpAddr),
    .outWrite  (dpWrite),
    .outTag    (dpTag),
    .outCore   (dpCore),
    .outTxn    (dpTxn),
    .lmRspMask (lmRspMask),
    .lmRspTag  (lmRspTag),
    .lmRspCore (lmRspCore),
    .lmRspTxn  (lmRspTxn),
    .dcRspMask (dcRspMask),
    .dcRspTag  (dcRspTag),
    .dcRspCore (dcRspCore),
    .dcRspTxn  (dcRspTxn),
    .upRspMask (upRspMask),
    .upRspTag  (upRspTag),
    .upRspCore (upRspCore),
    .upRspTxn  (upRspTxn)
  );

  assign lmReqValid = outValid[PATH_LM];
  assign lmReqMask  = dpMask[PATH_LM];
  assign lmReqAddr  = dpAddr[PATH_LM];
  assign lmReqWrite = dpWrite[PATH_LM];
  assign lmReqTag   = dpTag[PATH_LM];
  assign lmReqCore  = dpCore[PATH_LM];
  assign lmReqTxn   = dpTxn[PATH_LM];

  assign dcReqValid = outValid[PATH_DC];
  assign dcReqMask  = dpMask[PATH_DC];
  assign dcReqAddr  = dpAddr[PATH_DC];
  assign dcReqWrite = dpWrite[PATH_DC];
  assign dcReqTag   = dpTag[PATH_DC];
  assign dcReqCore  = dpCore[PATH_DC];
  assign dcReqTxn   = dpTxn[PATH_DC];
endmodule

// File: rtl/lrs_checker.sv
module lrs_checker #(
  parameter int          LANES       = 4,
  parameter int          ADDR_W      = 8,
  parameter int          TAG_W       = 4,
  parameter int unsigned SHARED_BASE = 64,
  parameter int unsigned SHARED_SIZE = 32
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    lmReqValid,
  input logic                    lmReqReady,
  input logic [LANES-1:0]        lmReqMask,
  input logic [LANES*ADDR_W-1:0] lmReqAddr,
  input logic [TAG_W-1:0]        lmReqTag,
  input logic                    dcReqValid,
  input logic                    dcReqReady,
  input logic [LANES-1:0]        dcReqMask,
  input logic [LANES*ADDR_W-1:0] dcReqAddr,
  input logic [TAG_W-1:0]        dcReqTag,
  input logic                    lmRspValid,
  input logic                    dcRspValid,
  input logic                    dcRspReady,
  input logic                    upRspValid,
  input logic [TAG_W-1:0]        lmRspTag,
  input logic [TAG_W-1:0]        upRspTag
);
  for (genvar i = 0; i < LANES; i++) begin : gChk
    int lmA, dcA;
    logic lmIn, dcIn;
    assign lmA  = int'(lmReqAddr[i*ADDR_W +: ADDR_W]);
    assign dcA  = int'(dcReqAddr[i*ADDR_W +: ADDR_W]);
    assign lmIn = (lmA >= int'(SHARED_BASE)) && (lmA < int'(SHARED_BASE + SHARED_SIZE));
    assign dcIn = (dcA >= int'(SHARED_BASE)) && (dcA < int'(SHARED_BASE + SHARED_SIZE));

    a_r1_local_lane_in_window: assert property (@(posedge clk) disable iff (!rstN)
      lmReqValid && lmReqMask[i] |-> lmIn);
    a_r1_cache_lane_outside: assert property (@(posedge clk) disable iff (!rstN)
      dcReqValid && dcReqMask[i] |-> !dcIn);
    a_r2_local_idle_slot_zero: assert property (@(posedge clk) disable iff (!rstN)
      lmReqValid && !lmReqMask[i] |-> lmA == 0);
    a_r2_cache_idle_slot_zero: assert property (@(posedge clk) disable iff (!rstN)
      dcReqValid && !dcReqMask[i] |-> dcA == 0);
  end

  a_r4_local_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    lmReqValid |-> lmReqMask != '0);
  a_r4_cache_nonempty: assert property (@(posedge clk) disable iff (!rstN)
    dcReqValid |-> dcReqMask != '0);
  a_r7_local_hold: assert property (@(posedge clk) disable iff (!rstN)
    lmReqValid && !lmReqReady |=> lmReqValid && $stable(lmReqMask) && $stable(lmReqTag));
  a_r7_cache_hold: assert property (@(posedge clk) disable iff (!rstN)
    dcReqValid && !dcReqReady |=> dcReqValid && $stable(dcReqMask) && $stable(dcReqTag));
  a_r8_local_wins: assert property (@(posedge clk) disable iff (!rstN)
    lmRspValid && dcRspValid |-> !dcRspReady && upRspValid && upRspTag == lmRspTag);
endmodule

bind lane_region_splitter lrs_checker #(
  .LANES(LANES), .ADDR_W(ADDR_W), .TAG_W(TAG_W),
  .SHARED_BASE(SHARED_BASE), .SHARED_SIZE(SHARED_SIZE)
) uChk (.*);

// File: tb/lane_region_splitter_test.sv
module lane_region_splitter_test;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int ADDR_W = 8;
  localparam int TAG_W = 4;
  localparam int CORE_W = 2;
  localparam int TXN_W = 4;
  localparam int BASE = 64;
  localparam int SIZE = 32;
  localparam int DELAY = 2;

  logic clk = 0, rstN = 0;
  logic inValid = 0, inReady;
  logic [LANES-1:0] inMask = '0;
  logic [LANES*ADDR_W-1:0] inAddr = '0;
  logic inWrite = 0;
  logic [TAG_W-1:0] inTag = '0;
  logic [CORE_W-1:0] inCore = '0;
  logic [TXN_W-1:0] inTxn = '0;
  logic lmReqValid, lmReqReady = 1, lmReqWrite;
  logic [LANES-1:0] lmReqMask;
  logic [LANES*ADDR_W-1:0] lmReqAddr;
  logic [TAG_W-1:0] lmReqTag;
  logic [CORE_W-1:0] lmReqCore;
  logic [TXN_W-1:0] lmReqTxn;
  logic dcReqValid, dcReqReady = 1, dcReqWrite;
  logic [LANES-1:0] dcReqMask;
  logic [LANES*ADDR_W-1:0] dcReqAddr;
  logic [TAG_W-1:0] dcReqTag;
  logic [CORE_W-1:0] dcReqCore;
  logic [TXN_W-1:0] dcReqTxn;
  logic lmRspValid = 0, lmRspReady;
  logic [LANES-1:0] lmRspMask = 4'b0011;
  logic [TAG_W-1:0] lmRspTag = 4'd5;
  logic [CORE_W-1:0] lmRspCore = 2'd1;
  logic [TXN_W-1:0] lmRspTxn = 4'd9;
  logic dcRspValid = 0, dcRspReady;
  logic [LANES-1:0] dcRspMask = 4'b1100;
  logic [TAG_W-1:0] dcRspTag = 4'd10;
  logic [CORE_W-1:0] dcRspCore = 2'd2;
  logic [TXN_W-1:0] dcRspTxn = 4'd6;
  logic upRspValid, upRspReady = 0;
  logic [LANES-1:0] upRspMask;
  logic [TAG_W-1:0] upRspTag;
  logic [CORE_W-1:0] upRspCore;
  logic [TXN_W-1:0] upRspTxn;

  int total = 0, bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_region_splitter #(
    .LANES(LANES), .ADDR_W(ADDR_W), .TAG_W(TAG_W), .CORE_W(CORE_W), .TXN_W(TXN_W),
    .SHARED_BASE(BASE), .SHARED_SIZE(SIZE), .DELAY(DELAY)
  ) uut (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inReady(inReady), .inMask(inMask), .inAddr(inAddr),
    .inWrite(inWrite), .inTag(inTag), .inCore(inCore), .inTxn(inTxn),
    .lmReqValid(lmReqValid), .lmReqReady(lmReqReady), .lmReqMask(lmReqMask),
    .lmReqAddr(lmReqAddr), .lmReqWrite(lmReqWrite), .lmReqTag(lmReqTag),
    .lmReqCore(lmReqCore), .lmReqTxn(lmReqTxn),
    .dcReqValid(dcReqValid), .dcReqReady(dcReqReady), .dcReqMask(dcReqMask),
    .dcReqAddr(dcReqAddr), .dcReqWrite(dcReqWrite), .dcReqTag(dcReqTag),
    .dcReqCore(dcReqCore), .dcReqTxn(dcReqTxn),
    .lmRspValid(lmRspValid), .lmRspReady(lmRspReady), .lmRspMask(lmRspMask),
    .lmRspTag(lmRspTag), .lmRspCore(lmRspCore), .lmRspTxn(lmRspTxn),
    .dcRspValid(dcRspValid), .dcRspReady(dcRspReady), .dcRspMask(dcRspMask),
    .dcRspTag(dcRspTag), .dcRspCore(dcRspCore), .dcRspTxn(dcRspTxn),
    .upRspValid(upRspValid), .upRspReady(upRspReady), .upRspMask(upRspMask),
    .upRspTag(upRspTag), .upRspCore(upRspCore), .upRspTxn(upRspTxn)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // boundary-heavy address pools: inside and outside the shared window
  function automatic logic [7:0] poolAddr(input bit shared, input int idx);
    logic [7:0] sh [4] = '{8'h40, 8'h5F, 8'h4A, 8'h51};
    logic [7:0] ns [4] = '{8'h3F, 8'h60, 8'h00, 8'hFF};
    return shared ? sh[idx % 4] : ns[idx % 4];
  endfunction

  task automatic runVec(input int v);
    logic [3:0] m, r, expLm, expDc;
    logic [31:0] addrs, expLmA, expDcA;
    m = 4'(v >> 4);
    r = 4'(v);
    expLm = m & r;
    expDc = m & ~r;
    for (int i = 0; i < LANES; i++) begin
      addrs[i*8 +: 8]  = poolAddr(r[i], i + v);
      expLmA[i*8 +: 8] = expLm[i] ? addrs[i*8 +: 8] : 8'h00;
      expDcA[i*8 +: 8] = expDc[i] ? addrs[i*8 +: 8] : 8'h00;
    end
    @(negedge clk);
    inValid = 1; inMask = m; inAddr = addrs;
    inWrite = v[0] ^ v[4]; inTag = 4'(v); inCore = 2'(v >> 4); inTxn = ~4'(v);
    #1 check(inReady === 1'b1, "R6 idle paths accept", 64'(inReady), 1);
    @(posedge clk);
    @(negedge clk);
    inValid = 0;
    #1 check(!lmReqValid && !dcReqValid, "R5 no early output",
             64'({lmReqValid, dcReqValid}), 0);
    @(posedge clk);
    @(negedge clk);
    #1;
    check(lmReqValid === (expLm != 0), "R4 local valid", 64'(lmReqValid), 64'(expLm != 0));
    check(dcReqValid === (expDc != 0), "R4 cache valid", 64'(dcReqValid), 64'(expDc != 0));
    if (expLm != 0) begin
      check(lmReqMask === expLm, "R1 local mask", 64'(lmReqMask), 64'(expLm));
      check(lmReqAddr === expLmA, "R2 local addr slots", 64'(lmReqAddr), 64'(expLmA));
      check({lmReqWrite, lmReqTag, lmReqCore, lmReqTxn} === {inWrite, inTag, inCore, inTxn},
            "R3 local fields", 64'({lmReqWrite, lmReqTag, lmReqCore, lmReqTxn}),
            64'({inWrite, inTag, inCore, inTxn}));
    end
    if (expDc != 0) begin
      check(dcReqMask === expDc, "R1 cache mask", 64'(dcReqMask), 64'(expDc));
      check(dcReqAddr === expDcA, "R2 cache addr slots", 64'(dcReqAddr), 64'(expDcA));
      check({dcReqWrite, dcReqTag, dcReqCore, dcReqTxn} === {inWrite, inTag, inCore, inTxn},
            "R3 cache fields", 64'({dcReqWrite, dcReqTag, dcReqCore, dcReqTxn}),
            64'({inWrite, inTag, inCore, inTxn}));
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1 check(!lmReqValid && !dcReqValid && !upRspValid, "R9 reset outputs idle",
             64'({lmReqValid, dcReqValid, upRspValid}), 0);

    // R1..R6 sweep: every mask against every lane region pattern
    for (int v = 0; v < 256; v++) runVec(v);

    // R6/R7 stall on the scratchpad path
    @(negedge clk);
    lmReqReady = 0;
    inValid = 1; inMask = 4'b0001; inAddr = 32'h00000040; inTag = 4'd1;
    #1 check(inReady === 1'b1, "R6 stall fill first", 64'(inReady), 1);
    @(posedge clk);
    @(negedge clk);
    inTag = 4'd2;
    #1 check(inReady === 1'b1, "R6 stall fill second", 64'(inReady), 1);
    @(posedge clk);
    @(negedge clk);
    inTag = 4'd3;
    #1 check(inReady === 1'b0, "R6 full local path blocks", 64'(inReady), 0);
    check(lmReqValid && lmReqTag == 4'd1, "R5 first at head", 64'(lmReqTag), 1);
    inAddr = 32'h00000010;
    #1 check(inReady === 1'b1, "R6 cache-only passes stall", 64'(inReady), 1);
    inMask = 4'b0011; inAddr = 32'h00001040;
    #1 check(inReady === 1'b0, "R6 mixed blocked", 64'(inReady), 0);
    inValid = 0;
    @(posedge clk);
    @(negedge clk);
    #1 check(lmReqValid && lmReqTag == 4'd1 && lmReqMask == 4'b0001, "R7 head held",
             64'(lmReqTag), 1);
    lmReqReady = 1;
    @(posedge clk);
    @(negedge clk);
    #1 check(lmReqValid && lmReqTag == 4'd2, "R7 order second", 64'(lmReqTag), 2);
    check(!dcReqValid, "R6 cache path untouched", 64'(dcReqValid), 0);
    @(posedge clk);
    @(negedge clk);
    #1 check(!lmReqValid, "R7 drained", 64'(lmReqValid), 0);

    // R8 response merge over all valid/ready combinations
    for (int c = 0; c < 8; c++) begin
      logic eV, eLR, eDR;
      logic [13:0] eF;
      @(negedge clk);
      lmRspValid = c[0]; dcRspValid = c[1]; upRspReady = c[2];
      eV  = c[0] | c[1];
      eLR = c[2];
      eDR = c[2] & ~c[0];
      eF  = c[0] ? {lmRspMask, lmRspTag, lmRspCore, lmRspTxn}
                 : {dcRspMask, dcRspTag, dcRspCore, dcRspTxn};
      #1;
      check(upRspValid === eV, "R8 merged valid", 64'(upRspValid), 64'(eV));
      check({lmRspReady, dcRspReady} === {eLR, eDR}, "R8 ready split",
            64'({lmRspReady, dcRspReady}), 64'({eLR, eDR}));
      if (eV)
        check({upRspMask, upRspTag, upRspCore, upRspTxn} === eF, "R8 merged fields",
              64'({upRspMask, upRspTag, upRspCore, upRspTxn}), 64'(eF));
    end
    lmRspValid = 0; dcRspValid = 0;
    finishRun();
  end
endmodule